// File: doc/BRIEF.md
# Dual-Read Register File

This block is the architectural register store of a small load/store processor core. It keeps a set of general-purpose entries and serves two operands to the execute stage through two independent read ports. It also accepts one result per cycle through a single write port. Each read port turns an entry index into that entry's contents through combinational logic only, so the operand is ready in the same cycle the index is presented.

Writes are clocked on the falling edge of `clk`. A datapath that advances on the rising edge can therefore fetch operands in the first half of a cycle and retire a result into the file in the middle of the same cycle. Entry zero is a constant: it reads as zero no matter what has been written to it. Reset is synchronous, active low and sampled on the falling edge, and it clears every entry so that simulation starts from a known state.

Top module: `dual_read_regfile`

## Requirements
- R1: While `rst_n` is low at a falling edge of `clk`, every entry is cleared, and all 32 addresses read back 0x00000000 on both ports afterwards.
- R2: Address 0 always reads 0x00000000 on either port, and a write with `wr_addr` = 0 changes nothing that can be read.
- R3: `rd_data_a` shows the entry selected by `rd_addr_a` with no clock edge in between; a change of `rd_addr_a` alone changes `rd_data_a`.
- R4: `rd_data_b` shows the entry selected by `rd_addr_b` in the same combinational way, independently of port A.
- R5: When `wr_en` is 1 at a falling edge of `clk`, `wr_data` is stored in the entry selected by `wr_addr`; a rising edge never stores anything.
- R6: When `wr_en` is 0 at a falling edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R7: A read of the entry being written returns the old contents from the rising edge up to the falling edge, and the new contents right after the falling edge.
- R8: A write changes only the entry it addresses; every other entry, including the neighbours of entries 1, 30 and 31, keeps its value.
- R9: Reset takes priority over a write presented at the same falling edge; the entry reads 0x00000000 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the falling edge |
| rd_addr_a | input | 5 | Entry index for read port A |
| rd_data_a | output | 32 | Contents of the entry chosen by `rd_addr_a` |
| rd_addr_b | input | 5 | Entry index for read port B |
| rd_data_b | output | 32 | Contents of the entry chosen by `rd_addr_b` |
| wr_en | input | 1 | Write request, 1 = store at the next falling edge |
| wr_addr | input | 5 | Entry index of the write |
| wr_data | input | 32 | Value to store |

## Verification
A read and a write of the same entry can fall in the same clock cycle, which is the case the falling-edge write exists for. Each table vector applies the write request and the read indices just after a rising edge. It samples both read ports before the falling edge and again just after it, and expects the old value in the first half of the cycle and the new value in the second. A directed case also applies a write just after a falling edge and checks that the following rising edge leaves the entry untouched.

// File: rtl/regfile_pkg.sv
// Package: regfile_pkg
// Shared sizing for the dual-read register file. Every width in the
// design is derived from these constants so the file can be resized
// in one place.
package regfile_pkg;
    localparam int unsigned RF_DEPTH = 32;
    localparam int unsigned RF_WIDTH = 32;
    localparam int unsigned RF_AW    = $clog2(RF_DEPTH);
endpackage

// File: rtl/rf_write_decode.sv
// Module: rf_write_decode
// Turns the write request into one strobe per entry. At most one strobe
// is high. The strobe for entry zero is held low because that entry is a
// constant. Assumes wr_addr < DEPTH whenever wr_en is high.
module rf_write_decode #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    parameter int unsigned AW    = regfile_pkg::RF_AW
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    output logic [DEPTH-1:0] wr_strobe
);
    // One comparator per entry; entry zero never receives a strobe.
    for (genvar k = 0; k < DEPTH; k++) begin : g_strobe
        if (k == 0) begin : g_const
            assign wr_strobe[k] = 1'b0;
        end else begin : g_cmp
            assign wr_strobe[k] = wr_en && (wr_addr == AW'(k));
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Module: rf_storage
// Holds the entries. Entries 1..DEPTH-1 are flops clocked on the falling
// edge, with a synchronous active-low clear. Entry zero is a constant and
// has no flop. Assumes the strobe vector is one-hot or all zero.
module rf_storage #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    parameter int unsigned WIDTH = regfile_pkg::RF_WIDTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            wr_strobe,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0] entries
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        if (k == 0) begin : g_zero
            assign entries[k] = '0;
        end else begin : g_flop
            logic [WIDTH-1:0] value_q;
            // Falling-edge update: clear has priority over a write.
            always_ff @(negedge clk) begin
                if (!rst_n) begin
                    value_q <= '0;
                end else if (wr_strobe[k]) begin
                    value_q <= wr_data;
                end
            end
            assign entries[k] = value_q;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
// Module: rf_read_port
// One combinational read port. It selects an entry by index and forces
// zero for index zero, so the port does not depend on how the storage
// builds entry zero. Assumes rd_addr < DEPTH.
module rf_read_port #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    parameter int unsigned WIDTH = regfile_pkg::RF_WIDTH,
    parameter int unsigned AW    = regfile_pkg::RF_AW
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] entries,
    input  logic [AW-1:0]               rd_addr,
    output logic [WIDTH-1:0]            rd_data
);
    // Entry selection with the constant-zero index overriding the mux.
    always_comb begin
        if (rd_addr == '0) begin
            rd_data = '0;
        end else begin
            rd_data = entries[rd_addr];
        end
    end
endmodule

// File: rtl/dual_read_regfile.sv
// Module: dual_read_regfile
// Register file with two combinational read ports and one write port that
// commits on the falling edge. Entry zero reads as zero. Reset is
// synchronous, active low and sampled on the falling edge. Assumes the
// surrounding datapath launches its signals from the rising edge.
module dual_read_regfile #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    parameter int unsigned WIDTH = regfile_pkg::RF_WIDTH,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr_a,
    output logic [WIDTH-1:0] rd_data_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);
    localparam int unsigned NUM_RD = 2;

    logic [DEPTH-1:0]            wr_strobe;
    logic [DEPTH-1:0][WIDTH-1:0] entries;
    logic [NUM_RD-1:0][AW-1:0]   rd_addr_v;
    logic [NUM_RD-1:0][WIDTH-1:0] rd_data_v;

    rf_write_decode #(.DEPTH(DEPTH), .AW(AW)) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_strobe (wr_strobe)
    );

    rf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .entries   (entries)
    );

    // Gather the read indices so the ports can be built in one loop.
    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_port (
            .entries (entries),
            .rd_addr (rd_addr_v[p]),
            .rd_data (rd_data_v[p])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];
endmodule

// File: rtl/dual_read_regfile_chk.sv
// Module: dual_read_regfile_chk
// Property checker attached to dual_read_regfile by the bind below. It
// watches the ports and the storage outputs.
module dual_read_regfile_chk #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    parameter int unsigned WIDTH = regfile_pkg::RF_WIDTH,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [AW-1:0]               rd_addr_a,
    input logic [WIDTH-1:0]            rd_data_a,
    input logic [AW-1:0]               rd_addr_b,
    input logic [WIDTH-1:0]            rd_data_b,
    input logic                        wr_en,
    input logic [AW-1:0]               wr_addr,
    input logic [WIDTH-1:0]            wr_data,
    input logic [DEPTH-1:0][WIDTH-1:0] entries
);
    assert_zero_port_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    assert_zero_port_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    assert_read_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a != '0) |-> (rd_data_a == entries[rd_addr_a]));

    assert_read_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b != '0) |-> (rd_data_b == entries[rd_addr_b]));

    for (genvar k = 1; k < DEPTH; k++) begin : g_ent
        assert_clear_R1: assert property (@(negedge clk)
            !rst_n |=> (entries[k] == '0));

        assert_write_lands_R5: assert property (@(negedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(k)) |=> (entries[k] == $past(wr_data)));

        assert_untouched_R8: assert property (@(negedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == AW'(k)) |=> $stable(entries[k]));
    end
endmodule

bind dual_read_regfile dual_read_regfile_chk #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .entries   (entries)
);

// File: tb/tb_dual_read_regfile.sv
// Bench for dual_read_regfile: a vector table walked by one loop, then
// directed tests for reset, combinational reads and edge selection.
module tb_dual_read_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    dual_read_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] a_pre;
        logic [31:0] b_pre;
        logic [31:0] a_post;
        logic [31:0] b_post;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd1,  32'h11111111, 5'd1,  5'd0,  32'h0,        32'h0,        32'h11111111, 32'h0},
        '{1'b1, 5'd2,  32'hA5A5A5A5, 5'd1,  5'd2,  32'h11111111, 32'h0,        32'h11111111, 32'hA5A5A5A5},
        '{1'b0, 5'd1,  32'hDEADBEEF, 5'd1,  5'd2,  32'h11111111, 32'hA5A5A5A5, 32'h11111111, 32'hA5A5A5A5},
        '{1'b1, 5'd0,  32'hFFFFFFFF, 5'd0,  5'd0,  32'h0,        32'h0,        32'h0,        32'h0},
        '{1'b1, 5'd31, 32'h80000001, 5'd31, 5'd1,  32'h0,        32'h11111111, 32'h80000001, 32'h11111111},
        '{1'b1, 5'd1,  32'h22222222, 5'd1,  5'd1,  32'h11111111, 32'h11111111, 32'h22222222, 32'h22222222},
        '{1'b1, 5'd30, 32'h0000FFFF, 5'd31, 5'd2,  32'h80000001, 32'hA5A5A5A5, 32'h80000001, 32'hA5A5A5A5},
        '{1'b0, 5'd30, 32'h12345678, 5'd30, 5'd0,  32'h0000FFFF, 32'h0,        32'h0000FFFF, 32'h0},
        '{1'b1, 5'd2,  32'h5A5A5A5A, 5'd30, 5'd31, 32'h0000FFFF, 32'h80000001, 32'h0000FFFF, 32'h80000001},
        '{1'b1, 5'd16, 32'hCAFEF00D, 5'd16, 5'd2,  32'h0,        32'h5A5A5A5A, 32'hCAFEF00D, 32'h5A5A5A5A}
    };

    // Compare one value and log a failure line when it differs.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Confirm that every address reads zero on both ports.
    task automatic sweep_zero(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_addr_a = 5'(i);
            rd_addr_b = 5'(31 - i);
            #0.1;
            check(req, rd_data_a, 32'h0);
            check(req, rd_data_b, 32'h0);
        end
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R1: all entries clear after reset.
        sweep_zero("R1");

        // Vector table: same-cycle read/write (R7), writes (R5), no-op (R6),
        // entry zero (R2), neighbours (R8).
        for (int v = 0; v < NV; v++) begin
            @(posedge clk); #1;
            wr_en = VECS[v].we; wr_addr = VECS[v].wa; wr_data = VECS[v].wd;
            rd_addr_a = VECS[v].ra; rd_addr_b = VECS[v].rb;
            #1;
            check("R7 pre A", rd_data_a, VECS[v].a_pre);
            check("R7 pre B", rd_data_b, VECS[v].b_pre);
            @(negedge clk); #1;
            check("R5/R6/R8 post A", rd_data_a, VECS[v].a_post);
            check("R5/R2 post B", rd_data_b, VECS[v].b_post);
        end
        wr_en = 1'b0;

        // R3/R4: address changes alone move the outputs, no clock needed.
        @(posedge clk); #1;
        rd_addr_a = 5'd16; rd_addr_b = 5'd31; #1;
        check("R3", rd_data_a, 32'hCAFEF00D);
        check("R4", rd_data_b, 32'h80000001);
        rd_addr_a = 5'd2; #1;
        check("R3", rd_data_a, 32'h5A5A5A5A);
        check("R4 independent", rd_data_b, 32'h80000001);
        rd_addr_b = 5'd1; #1;
        check("R4", rd_data_b, 32'h22222222);
        check("R3 independent", rd_data_a, 32'h5A5A5A5A);

        // R5: a request set up after a falling edge is not stored by the rising edge.
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h0BADCAFE;
        rd_addr_a = 5'd7;
        @(posedge clk); #1;
        check("R5 rising edge", rd_data_a, 32'h0);
        @(negedge clk); #1;
        check("R5 falling edge", rd_data_a, 32'h0BADCAFE);
        wr_en = 1'b0;

        // R9: reset wins over a simultaneous write.
        @(posedge clk); #1;
        rst_n = 1'b0; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h99999999;
        @(negedge clk); #1;
        wr_en = 1'b0;
        rd_addr_a = 5'd9; #0.1;
        check("R9", rd_data_a, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        sweep_zero("R1 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule